// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block turns a single burst request into the list of byte addresses for every data transfer of that burst. A master loads it once with a start address, a sequence kind, a word size and, for a burst of known length, a transfer count. The block then presents one address per transfer and moves to the next address each time a transfer is both offered and taken. The target therefore learns at the start that more transfers will follow, and it can fetch ahead.

Four address orders are built in: a rising address, a rising address that wraps inside an aligned window, an order that XORs the beat number into the start index, and a fixed address that repeats. The burst length is either known at load time (precise), in which case an internal down-counter marks the final transfer, or not known (imprecise), in which case the master marks the final transfer itself. Load requests that combine these settings in a way the block cannot serve are refused and reported.

The control is a two-state machine. `ST_IDLE` waits for a load. The transition *start* (legal load) enters `ST_RUN`, and a refused load stays in `ST_IDLE`. In `ST_RUN`, *advance* (transfer taken, not final) stays in `ST_RUN`, *finish* (final transfer taken, no load) returns to `ST_IDLE`, and *chain* (final transfer taken together with a legal load) stays in `ST_RUN` with the new burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, busy_o, last_o and err_o are 0 and addr_o is 0.
- R2: A load taken in ST_IDLE with legal settings makes busy_o 1 in the next cycle, with addr_o equal to the loaded start address.
- R3: While busy, addr_o and busy_o do not change in any cycle in which valid_i and accept_i are not both 1.
- R4: Kind code 000 (rising) adds 2^size_log2_i bytes to the address on each taken non-final transfer.
- R5: Kind code 001 (wrap) stays inside a window of length × 2^size bytes aligned to its own size, rising by the word size and returning to the window base after the top.
- R6: Kind code 010 (XOR) gives at beat b the address base | (((start_index XOR b) mod length) × word size), where base is the start address aligned to the window of length × word size and start_index is the start address's word index inside that window.
- R7: Kind code 011 (fixed) repeats the start address on every transfer.
- R8: In a precise burst (precise_i = 1), last_o is 1 exactly while one transfer remains, and after that transfer is taken with no load, busy_o is 0 in the next cycle.
- R9: In an imprecise burst (precise_i = 0), last_o follows imp_last_i in the same cycle, and the burst ends on the taken transfer that carries it.
- R10: A load is refused, with err_o set to 1 and no burst started, when the kind code is 100 to 111, when a precise burst has length 0, or when wrap or XOR is asked for with an imprecise burst or a length that is not a power of two; err_o returns to 0 on the next legal load.
- R11: A legal load in the same cycle as the taken final transfer starts the new burst in the next cycle with no idle cycle between.
- R12: A load while busy in a cycle that does not take the final transfer is ignored: the running burst continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Request to start a burst with the settings below |
| start_addr_i | input | ADDR_W | First byte address of the burst |
| seq_kind_i | input | 3 | Address order: 000 rising, 001 wrap, 010 XOR, 011 fixed |
| size_log2_i | input | SIZE_W | Word size as log2 of bytes |
| burst_len_i | input | LEN_W | Transfer count for a precise burst |
| precise_i | input | 1 | 1 = length known at load, 0 = master marks the end |
| valid_i | input | 1 | Master offers the current transfer |
| accept_i | input | 1 | Target takes the current transfer |
| imp_last_i | input | 1 | Master marks the final transfer of an imprecise burst |
| addr_o | output | ADDR_W | Address of the current transfer |
| busy_o | output | 1 | A burst is in progress |
| last_o | output | 1 | Current transfer is the final one |
| err_o | output | 1 | Last load was refused |

## Verification
The taken final transfer of one burst and the load of the next can fall in the same cycle, and that cycle decides whether the load is taken or ignored. The bench provokes it by holding valid_i and accept_i high exactly when its model shows one transfer left and asserting load_i with different settings in that cycle, and also by asserting load_i one cycle earlier in the middle of a burst. A model of the burst state, updated on every rising edge from the same inputs, judges busy_o, addr_o and last_o in each following cycle, so a dropped chain or a taken mid-burst load shows up as a wrong address or a wrong busy level.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [2:0] {
        SEQ_INCR   = 3'b000,
        SEQ_WRAP   = 3'b001,
        SEQ_XOR    = 3'b010,
        SEQ_STREAM = 3'b011
    } seq_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bag_state_e;

endpackage

// File: rtl/burst_beat_track.sv
module burst_beat_track #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             precise_i,
    input  logic             busy_i,
    input  logic             fire_i,
    input  logic             imp_last_i,
    output logic [LEN_W-1:0] beat_o,
    output logic             last_o
);

    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] beat_q;
    logic             precise_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q  <= '0;
            beat_q    <= '0;
            precise_q <= 1'b0;
        end else if (start_i) begin
            remain_q  <= len_i;
            beat_q    <= '0;
            precise_q <= precise_i;
        end else if (fire_i) begin
            remain_q  <= remain_q - 1'b1;
            beat_q    <= beat_q + 1'b1;
        end
    end

    always_comb begin
        last_o = precise_q ? (remain_q == LEN_W'(1)) : imp_last_i;
        beat_o = beat_q;
    end

    // R8: a running precise burst never has an exhausted count
    p_count_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && precise_q |-> remain_q != '0);

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next import burst_addr_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 2
) (
    input  seq_kind_e         kind_i,
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] win_mask_i,
    input  logic [LEN_W-1:0]  idx_mask_i,
    input  logic [LEN_W-1:0]  sidx_i,
    input  logic [LEN_W-1:0]  beat_nxt_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [ADDR_W-1:0] nxt_o
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] xor_off;

    always_comb begin
        step    = ADDR_W'(1) << size_i;
        xor_off = ADDR_W'((sidx_i ^ beat_nxt_i) & idx_mask_i) << size_i;
        unique case (kind_i)
            SEQ_INCR:   nxt_o = cur_i + step;
            SEQ_WRAP:   nxt_o = base_i | ((cur_i + step) & win_mask_i);
            SEQ_XOR:    nxt_o = base_i | xor_off;
            SEQ_STREAM: nxt_o = cur_i;
            default:    nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen import burst_addr_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [2:0]        seq_kind_i,
    input  logic [SIZE_W-1:0] size_log2_i,
    input  logic [LEN_W-1:0]  burst_len_i,
    input  logic              precise_i,
    input  logic              valid_i,
    input  logic              accept_i,
    input  logic              imp_last_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              last_o,
    output logic              err_o
);

    localparam int PAD_W = ADDR_W - LEN_W;

    bag_state_e        state_q, state_d;
    seq_kind_e         kind_q;
    logic [SIZE_W-1:0] size_q;
    logic [ADDR_W-1:0] cur_q, base_q, win_mask_q;
    logic [LEN_W-1:0]  idx_mask_q, sidx_q;
    logic              err_q;

    logic              busy, fire, trk_last, final_acc, load_take, req_legal, len_pow2;
    logic [ADDR_W-1:0] ld_mask, nxt_addr;
    logic [LEN_W-1:0]  beat, ld_sidx;

    assign busy      = (state_q == ST_RUN);
    assign fire      = busy && valid_i && accept_i;
    assign final_acc = fire && trk_last;
    assign load_take = load_i && (!busy || final_acc);

    always_comb begin
        len_pow2  = (burst_len_i != '0) && ((burst_len_i & (burst_len_i - 1'b1)) == '0);
        req_legal = 1'b1;
        if (seq_kind_i > 3'b011)
            req_legal = 1'b0;
        if (precise_i && burst_len_i == '0)
            req_legal = 1'b0;
        if ((seq_kind_i == 3'b001 || seq_kind_i == 3'b010) && (!precise_i || !len_pow2))
            req_legal = 1'b0;
        ld_mask = ADDR_W'({{PAD_W{1'b0}}, burst_len_i} << size_log2_i) - 1'b1;
        ld_sidx = LEN_W'((start_addr_i & ld_mask) >> size_log2_i);
    end

    // next state: start, advance, finish, chain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_take && req_legal) state_d = ST_RUN;
            ST_RUN: begin
                if (load_take)      state_d = req_legal ? ST_RUN : ST_IDLE;
                else if (final_acc) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= SEQ_INCR;
            size_q     <= '0;
            cur_q      <= '0;
            base_q     <= '0;
            win_mask_q <= '0;
            idx_mask_q <= '0;
            sidx_q     <= '0;
            err_q      <= 1'b0;
        end else if (load_take) begin
            err_q <= !req_legal;
            if (req_legal) begin
                kind_q     <= seq_kind_e'(seq_kind_i);
                size_q     <= size_log2_i;
                cur_q      <= start_addr_i;
                base_q     <= start_addr_i & ~ld_mask;
                win_mask_q <= ld_mask;
                idx_mask_q <= burst_len_i - 1'b1;
                sidx_q     <= ld_sidx;
            end
        end else if (fire && !trk_last) begin
            cur_q <= nxt_addr;
        end
    end

    burst_beat_track #(.LEN_W(LEN_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (load_take && req_legal),
        .len_i      (burst_len_i),
        .precise_i  (precise_i),
        .busy_i     (busy),
        .fire_i     (fire),
        .imp_last_i (imp_last_i),
        .beat_o     (beat),
        .last_o     (trk_last)
    );

    burst_addr_next #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_next (
        .kind_i     (kind_q),
        .cur_i      (cur_q),
        .base_i     (base_q),
        .win_mask_i (win_mask_q),
        .idx_mask_i (idx_mask_q),
        .sidx_i     (sidx_q),
        .beat_nxt_i (beat + 1'b1),
        .size_i     (size_q),
        .nxt_o      (nxt_addr)
    );

    assign addr_o = cur_q;
    assign busy_o = busy;
    assign last_o = busy && trk_last;
    assign err_o  = err_q;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !(valid_i && accept_i) |=> busy_o && $stable(addr_o));

    p_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && kind_q == SEQ_STREAM && fire && !last_o |=> addr_o == $past(addr_o));

    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && kind_q == SEQ_WRAP |-> (addr_o & ~win_mask_q) == base_q);

    p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire && last_o && !load_i |=> !busy_o);

    p_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);

    p_chain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire && last_o && load_i && req_legal |=> busy_o && addr_o == $past(start_addr_i));

endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] start_addr_i = '0;
    logic [2:0]  seq_kind_i = '0;
    logic [1:0]  size_log2_i = '0;
    logic [7:0]  burst_len_i = '0;
    logic        precise_i = 1'b0;
    logic        valid_i = 1'b0;
    logic        accept_i = 1'b0;
    logic        imp_last_i = 1'b0;
    logic [15:0] addr_o;
    logic        busy_o, last_o, err_o;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    bit          m_busy, m_err, m_prec;
    int          m_kind, m_size, m_len, m_rem, m_beat;
    int          m_start, m_addr;

    burst_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
        .seq_kind_i(seq_kind_i), .size_log2_i(size_log2_i), .burst_len_i(burst_len_i),
        .precise_i(precise_i), .valid_i(valid_i), .accept_i(accept_i),
        .imp_last_i(imp_last_i), .addr_o(addr_o), .busy_o(busy_o), .last_o(last_o),
        .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    function automatic int addr_at(int b);
        int bytes, win, base;
        bytes = 1 << m_size;
        win   = m_len * bytes;
        base  = (win > 0) ? (m_start / win) * win : 0;
        case (m_kind)
            0: return (m_start + b * bytes) % 65536;
            1: return base + ((m_start - base + b * bytes) % win);
            2: return base + ((((m_start % win) / bytes) ^ b) % m_len) * bytes;
            default: return m_start;
        endcase
    endfunction

    function automatic bit is_legal(int k, int ln, bit pr);
        if (k > 3) return 0;
        if (pr && ln == 0) return 0;
        if ((k == 1 || k == 2) && (!pr || ln == 0 || (ln & (ln - 1)) != 0)) return 0;
        return 1;
    endfunction

    function automatic bit m_last();
        return m_busy && (m_prec ? (m_rem == 1) : imp_last_i);
    endfunction

    always @(posedge clk) begin
        bit fire, fin, take;
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_addr = 0; m_rem = 0; m_beat = 0;
        end else begin
            fire = m_busy && valid_i && accept_i;
            fin  = fire && m_last();
            take = load_i && (!m_busy || fin);
            if (take) begin
                if (is_legal(int'(seq_kind_i), int'(burst_len_i), precise_i)) begin
                    m_err = 0; m_busy = 1; m_kind = int'(seq_kind_i);
                    m_size = int'(size_log2_i); m_len = int'(burst_len_i);
                    m_prec = precise_i; m_start = int'(start_addr_i);
                    m_addr = m_start; m_rem = m_len; m_beat = 0;
                end else begin
                    m_err = 1; m_busy = 0;
                end
            end else if (fin) begin
                m_busy = 0;
            end else if (fire) begin
                m_beat++; m_rem--; m_addr = addr_at(m_beat);
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // wait for the inactive edge, compare against the model, then the caller drives
    task automatic step();
        @(negedge clk);
        check("busy", int'(busy_o), int'(m_busy));
        check("addr", int'(addr_o), m_addr);
        check("last", int'(last_o), int'(m_last()));
        check("err",  int'(err_o),  int'(m_err));
        load_i = 1'b0;
    endtask

    task automatic drive_load(int k, int sz, int ln, bit pr, int a);
        load_i = 1'b1; seq_kind_i = 3'(k); size_log2_i = 2'(sz);
        burst_len_i = 8'(ln); precise_i = pr; start_addr_i = 16'(a);
    endtask

    task automatic random_xfer(int imp_n);
        valid_i    = ($urandom % 4) != 0;
        accept_i   = ($urandom % 4) != 0;
        imp_last_i = (m_beat >= imp_n - 1);
    endtask

    task automatic burst(int k, int sz, int ln, bit pr, int a, int imp_n);
        step();
        drive_load(k, sz, ln, pr, a);
        valid_i = 1'b0; accept_i = 1'b0;
        step();
        if (is_legal(k, ln, pr)) check("R2 start address", int'(addr_o), a);
        for (int i = 0; i < 300 && m_busy; i++) begin
            random_xfer(imp_n);
            step();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1 busy", int'(busy_o), 0);
        check("R1 last", int'(last_o), 0);
        check("R1 err",  int'(err_o),  0);
        check("R1 addr", int'(addr_o), 0);
        rst_n = 1'b1;

        tag = "R4 R8 R3"; burst(0, 2, 4, 1, 'h100, 0);
        tag = "R4 size1"; burst(0, 1, 6, 1, 'hFFFA, 0);
        tag = "R5";       burst(1, 2, 4, 1, 'h38, 0);
        tag = "R5 len8";  burst(1, 0, 8, 1, 'h2D, 0);
        tag = "R6";       burst(2, 0, 8, 1, 'h45, 0);
        tag = "R6 size2"; burst(2, 2, 4, 1, 'h28, 0);
        tag = "R7";       burst(3, 1, 3, 1, 'h77, 0);
        tag = "R9";       burst(0, 0, 0, 0, 'h300, 5);
        tag = "R9 fixed"; burst(3, 2, 0, 0, 'h444, 3);

        tag = "R10 code"; burst(5, 0, 4, 1, 'h10, 0);
        check("R10 err after bad code", int'(err_o), 1);
        tag = "R10 wrap len3";   burst(1, 0, 3, 1, 'h10, 0);
        tag = "R10 xor imprecise"; burst(2, 0, 4, 0, 'h10, 0);
        tag = "R10 len0";        burst(0, 0, 0, 1, 'h10, 0);
        tag = "R10 clear";       burst(0, 0, 2, 1, 'h20, 0);
        check("R10 err cleared", int'(err_o), 0);

        // R11: load in the cycle that takes the final transfer
        tag = "R11";
        step();
        drive_load(0, 2, 2, 1, 'h500);
        step();
        for (int i = 0; i < 50 && m_busy; i++) begin
            if (m_rem == 1) begin
                valid_i = 1'b1; accept_i = 1'b1;
                drive_load(1, 1, 4, 1, 'h606);
                step();
                check("R11 no gap busy", int'(busy_o), 1);
                check("R11 new start", int'(addr_o), 'h606);
                break;
            end
            random_xfer(0);
            step();
        end
        for (int i = 0; i < 100 && m_busy; i++) begin
            random_xfer(0);
            step();
        end

        // R12: load in mid-burst is ignored
        tag = "R12";
        step();
        drive_load(0, 0, 4, 1, 'h700);
        step();
        valid_i = 1'b1; accept_i = 1'b1;
        step();
        valid_i = 1'b0;
        drive_load(3, 0, 2, 1, 'h900);
        step();
        check("R12 still running", int'(busy_o), 1);
        check("R12 address kept", int'(addr_o), 'h701);
        for (int i = 0; i < 100 && m_busy; i++) begin
            random_xfer(0);
            step();
        end
        check("R12 burst ended", int'(busy_o), 0);
        check("R12 final addr", int'(addr_o), 'h703);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule